// File: doc/BRIEF.md
# Accumulator ALU with Scaling Shifters

This block is the arithmetic heart of a small fixed-point datapath. A 32-bit accumulator register serves as both the destination and the second operand of every arithmetic and logic operation. The other operand is a 16-bit word, taken either from a data-memory read port or from an immediate field. It is extended to 32 bits, either sign- or zero-extended, and then moved left by a programmable amount before it meets the accumulator. Add and subtract update a carry flag and a signed-overflow flag. AND, OR and XOR leave both flags alone.

A store operation sends one 16-bit half of the accumulator to a write port. The value first passes through a separate left shifter of 0 to 7 places, so bits from the low half can move up into the stored high half. The accumulator itself is never changed by a store. There are also two load operations. A long load replaces the whole accumulator with the scaled operand. A short load replaces only the low half and keeps the high half.

Each operation is presented for one cycle with `op_valid` high. Its result is visible on the outputs after the next rising clock edge.

Top module: `acc_alu_shift`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `acc_q` is 0, `carry` is 0, `ovf` is 0 and `wr_en` is 0.
- R2: The operand is built in four steps. The source is `imm_data` when `use_imm` is 1 and `mem_rdata` when it is 0. The source is sign-extended to 32 bits when `sxm` is 1 and zero-extended when it is 0. It is then shifted left by `shift_amt` places. Any `shift_amt` above 16 is treated as 16.
- R3: Code 1 (add) sets `acc_q` to `acc_q` + operand, modulo 2^32, one clock edge after the operation is accepted.
- R4: Code 2 (subtract) sets `acc_q` to `acc_q` − operand, modulo 2^32.
- R5: On add and subtract, two flags are updated. `carry` takes bit 32 of the 33-bit sum: `acc_q`+operand for add, and `acc_q`+~operand+1 for subtract, so carry 1 means no borrow. `ovf` is set when the 32-bit signed result has overflowed.
- R6: Codes 3, 4 and 5 set `acc_q` to the bitwise AND, OR and XOR of `acc_q` with the operand. `carry` and `ovf` keep their values.
- R7: Code 6 (short load) sets `acc_q[15:0]` to the unextended, unshifted 16-bit source. `acc_q[31:16]`, `carry` and `ovf` keep their values.
- R8: Code 7 (long load) sets `acc_q` to the operand. The flags keep their values.
- R9: Code 8 (store) drives `wr_en` high for exactly the following cycle. `wr_data` then holds bits [31:16] of (`acc_q` << `shift_amt[2:0]`) when `store_hi` is 1, and bits [15:0] of that value when it is 0. `acc_q`, `carry` and `ovf` do not change.
- R10: When `op_valid` is 0, or the code is 0 or any value from 9 to 15, nothing changes: `acc_q` and the flags keep their values, and `wr_en` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, one operation per cycle |
| op_code | input | 4 | Operation code (see requirements) |
| use_imm | input | 1 | 1 selects the immediate field, 0 selects the memory read data |
| imm_data | input | 16 | Immediate operand |
| mem_rdata | input | 16 | Operand from data memory |
| sxm | input | 1 | 1 selects sign extension, 0 selects zero extension |
| shift_amt | input | 5 | Input shift count 0..16 (above 16 clamps); bits [2:0] give the store shift |
| store_hi | input | 1 | 1 stores the high half, 0 stores the low half |
| acc_q | output | 32 | Accumulator |
| carry | output | 1 | Carry / not-borrow flag |
| ovf | output | 1 | Signed overflow flag |
| wr_en | output | 1 | Store write strobe |
| wr_data | output | 16 | Store write data |

## Verification
Every result is registered once. A change to `acc_q`, `carry` or `ovf`, and the `wr_en`/`wr_data` pair of a store, becomes due at the first rising edge after the cycle in which the operation was presented. The bench drives each operation at a falling edge and removes `op_valid` at the next falling edge. It compares all outputs against its model at that same falling edge, half a period after the update. Because `op_valid` is then low, the one-cycle width of the store strobe is also checked on the following operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   typedef enum logic [3:0] {
      OP_NOP  = 4'd0,
      OP_ADD  = 4'd1,
      OP_SUB  = 4'd2,
      OP_AND  = 4'd3,
      OP_OR   = 4'd4,
      OP_XOR  = 4'd5,
      OP_LDLO = 4'd6,
      OP_LDL  = 4'd7,
      OP_STO  = 4'd8
   } alu_op_e;
endpackage

// File: rtl/operand_scaler.sv
module operand_scaler #(
   parameter int OPW  = 16,
   parameter int ACCW = 32,
   parameter int ISHW = 5,
   parameter int IMAX = 16
) (
   input  logic [OPW-1:0]  src,
   input  logic            sxm,
   input  logic [ISHW-1:0] amt,
   output logic [ACCW-1:0] opnd
);
   localparam logic [ISHW-1:0] MAXV = ISHW'(IMAX);

   if (IMAX >= (1 << ISHW)) begin : g_bad_cnt
      $error("operand_scaler: IMAX does not fit in shift field");
   end
   if (ACCW < OPW + IMAX) begin : g_bad_w
      $error("operand_scaler: ACCW too narrow for maximum shift");
   end

   logic [ISHW-1:0] amt_c;
   logic [ACCW-1:0] stg [ISHW+1];

   assign amt_c  = (amt > MAXV) ? MAXV : amt;
   assign stg[0] = sxm ? {{(ACCW-OPW){src[OPW-1]}}, src}
                       : {{(ACCW-OPW){1'b0}}, src};

   for (genvar k = 0; k < ISHW; k++) begin : g_stage
      assign stg[k+1] = amt_c[k] ? (stg[k] << (1 << k)) : stg[k];
   end

   assign opnd = stg[ISHW];
endmodule

// File: rtl/store_scaler.sv
module store_scaler #(
   parameter int OPW  = 16,
   parameter int ACCW = 32,
   parameter int OSHW = 3
) (
   input  logic [ACCW-1:0] acc,
   input  logic [OSHW-1:0] amt,
   input  logic            hi,
   output logic [OPW-1:0]  data
);
   if (ACCW != 2 * OPW) begin : g_bad_w
      $error("store_scaler: ACCW must be twice OPW");
   end

   logic [ACCW-1:0] stg [OSHW+1];
   assign stg[0] = acc;

   for (genvar k = 0; k < OSHW; k++) begin : g_stage
      assign stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
   end

   assign data = hi ? stg[OSHW][ACCW-1:OPW] : stg[OSHW][OPW-1:0];
endmodule

// File: rtl/alu_core.sv
module alu_core
   import acc_alu_pkg::*;
#(
   parameter int OPW  = 16,
   parameter int ACCW = 32
) (
   input  alu_op_e         op,
   input  logic [ACCW-1:0] acc,
   input  logic [ACCW-1:0] opnd,
   input  logic [OPW-1:0]  raw,
   output logic [ACCW-1:0] nxt,
   output logic            nxt_c,
   output logic            nxt_v,
   output logic            upd_acc,
   output logic            upd_flg
);
   localparam int MSB = ACCW - 1;

   logic [ACCW:0] sum_add, sum_sub;
   assign sum_add = {1'b0, acc} + {1'b0, opnd};
   assign sum_sub = {1'b0, acc} + {1'b0, ~opnd} + {{ACCW{1'b0}}, 1'b1};

   always_comb begin
      nxt     = acc;
      nxt_c   = 1'b0;
      nxt_v   = 1'b0;
      upd_acc = 1'b1;
      upd_flg = 1'b0;
      unique case (op)
         OP_ADD: begin
            nxt     = sum_add[MSB:0];
            nxt_c   = sum_add[ACCW];
            nxt_v   = (acc[MSB] == opnd[MSB]) && (sum_add[MSB] != acc[MSB]);
            upd_flg = 1'b1;
         end
         OP_SUB: begin
            nxt     = sum_sub[MSB:0];
            nxt_c   = sum_sub[ACCW];
            nxt_v   = (acc[MSB] != opnd[MSB]) && (sum_sub[MSB] != acc[MSB]);
            upd_flg = 1'b1;
         end
         OP_AND:  nxt = acc & opnd;
         OP_OR:   nxt = acc | opnd;
         OP_XOR:  nxt = acc ^ opnd;
         OP_LDLO: nxt = {acc[MSB:OPW], raw};
         OP_LDL:  nxt = opnd;
         default: upd_acc = 1'b0;
      endcase
   end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
   import acc_alu_pkg::*;
#(
   parameter int OPW  = 16,
   parameter int ACCW = 32,
   parameter int ISHW = 5,
   parameter int OSHW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_valid,
   input  logic [3:0]      op_code,
   input  logic            use_imm,
   input  logic [OPW-1:0]  imm_data,
   input  logic [OPW-1:0]  mem_rdata,
   input  logic            sxm,
   input  logic [ISHW-1:0] shift_amt,
   input  logic            store_hi,
   output logic [ACCW-1:0] acc_q,
   output logic            carry,
   output logic            ovf,
   output logic            wr_en,
   output logic [OPW-1:0]  wr_data
);
   localparam int IMAX = OPW;

   if (OSHW > ISHW) begin : g_bad_osh
      $error("acc_alu_shift: store shift field wider than shift input");
   end

   alu_op_e         op;
   logic [OPW-1:0]  src;
   logic [ACCW-1:0] opnd, nxt;
   logic [OPW-1:0]  st_data;
   logic            nxt_c, nxt_v, upd_acc, upd_flg;

   assign op  = alu_op_e'(op_code);
   assign src = use_imm ? imm_data : mem_rdata;

   operand_scaler #(.OPW(OPW), .ACCW(ACCW), .ISHW(ISHW), .IMAX(IMAX)) u_in (
      .src(src), .sxm(sxm), .amt(shift_amt), .opnd(opnd));

   alu_core #(.OPW(OPW), .ACCW(ACCW)) u_alu (
      .op(op), .acc(acc_q), .opnd(opnd), .raw(src), .nxt(nxt),
      .nxt_c(nxt_c), .nxt_v(nxt_v), .upd_acc(upd_acc), .upd_flg(upd_flg));

   store_scaler #(.OPW(OPW), .ACCW(ACCW), .OSHW(OSHW)) u_out (
      .acc(acc_q), .amt(shift_amt[OSHW-1:0]), .hi(store_hi), .data(st_data));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         carry   <= 1'b0;
         ovf     <= 1'b0;
         wr_en   <= 1'b0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (op_valid) begin
            if (upd_acc) acc_q <= nxt;
            if (upd_flg) begin
               carry <= nxt_c;
               ovf   <= nxt_v;
            end
            if (op == OP_STO) begin
               wr_en   <= 1'b1;
               wr_data <= st_data;
            end
         end
      end
   end
endmodule

// File: rtl/acc_alu_shift_chk.sv
module acc_alu_shift_chk #(
   parameter int ACCW = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            op_valid,
   input logic [3:0]      op_code,
   input logic [ACCW-1:0] acc_q,
   input logic            carry,
   input logic            ovf,
   input logic            wr_en
);
   logic is_store, is_logic, is_ldlo, is_idle;
   assign is_store = op_valid && (op_code == 4'd8);
   assign is_logic = op_valid && (op_code >= 4'd3) && (op_code <= 4'd5);
   assign is_ldlo  = op_valid && (op_code == 4'd6);
   assign is_idle  = !op_valid || (op_code == 4'd0) || (op_code > 4'd8);

   AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      is_store |=> $stable(acc_q) && $stable(carry) && $stable(ovf)); // R9
   AST_WR_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(is_store)); // R9
   AST_LOGIC_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      is_logic |=> $stable(carry) && $stable(ovf)); // R6
   AST_SHORT_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      is_ldlo |=> $stable(acc_q[ACCW-1:ACCW/2])); // R7
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      is_idle |=> $stable(acc_q) && !wr_en); // R10
endmodule

bind acc_alu_shift acc_alu_shift_chk #(.ACCW(ACCW)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
   .acc_q(acc_q), .carry(carry), .ovf(ovf), .wr_en(wr_en));

// File: tb/sim_acc_alu_shift.sv
module sim_acc_alu_shift;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic        use_imm = 1'b0;
   logic [15:0] imm_data = '0, mem_rdata = '0;
   logic        sxm = 1'b0;
   logic [4:0]  shift_amt = '0;
   logic        store_hi = 1'b0;
   logic [31:0] acc_q;
   logic        carry, ovf, wr_en;
   logic [15:0] wr_data;

   int errors = 0, checks = 0;
   bit done = 0;
   logic [31:0] m_acc = '0;
   logic        m_c = 1'b0, m_v = 1'b0;

   always #10 clk = ~clk;

   acc_alu_shift u0 (.*);

   function automatic logic [31:0] scale_in(logic [15:0] s, logic sx, logic [4:0] n);
      logic [31:0] e;
      int k;
      e = sx ? 32'(signed'(s)) : {16'h0, s};
      k = (n > 5'd16) ? 16 : int'(n);
      return e << k;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic do_op(logic v, logic [3:0] op, logic ui, logic [15:0] imm,
                        logic [15:0] mem, logic sx, logic [4:0] sh, logic hi);
      logic [15:0] s;
      logic [31:0] o, so;
      logic [32:0] w;
      logic        ewen;
      logic [15:0] edat;
      string       tag, ftag;
      s = ui ? imm : mem;
      o = scale_in(s, sx, sh);
      ewen = 1'b0; edat = '0; tag = "R10"; ftag = "R10";
      if (v) begin
         case (op)
            4'd1: begin
               w = {1'b0, m_acc} + {1'b0, o};
               m_v = (m_acc[31] == o[31]) && (w[31] != m_acc[31]);
               m_c = w[32]; m_acc = w[31:0]; tag = "R3 R2"; ftag = "R5";
            end
            4'd2: begin
               w = {1'b0, m_acc} + {1'b0, ~o} + 33'd1;
               m_v = (m_acc[31] != o[31]) && (w[31] != m_acc[31]);
               m_c = w[32]; m_acc = w[31:0]; tag = "R4 R2"; ftag = "R5";
            end
            4'd3: begin m_acc = m_acc & o; tag = "R6"; ftag = "R6"; end
            4'd4: begin m_acc = m_acc | o; tag = "R6"; ftag = "R6"; end
            4'd5: begin m_acc = m_acc ^ o; tag = "R6"; ftag = "R6"; end
            4'd6: begin m_acc[15:0] = s; tag = "R7"; ftag = "R7"; end
            4'd7: begin m_acc = o; tag = "R8 R2"; ftag = "R8"; end
            4'd8: begin
               so = m_acc << sh[2:0];
               edat = hi ? so[31:16] : so[15:0];
               ewen = 1'b1; tag = "R9"; ftag = "R9";
            end
            default: ;
         endcase
      end
      op_valid = v; op_code = op; use_imm = ui; imm_data = imm; mem_rdata = mem;
      sxm = sx; shift_amt = sh; store_hi = hi;
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0;
      chk(tag, "acc", acc_q, m_acc);
      chk(ftag, "carry", {31'h0, carry}, {31'h0, m_c});
      chk(ftag, "ovf", {31'h0, ovf}, {31'h0, m_v});
      chk(tag, "wr_en", {31'h0, wr_en}, {31'h0, ewen});
      if (ewen) chk("R9", "wr_data", {16'h0, wr_data}, {16'h0, edat});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      chk("R1", "acc in reset", acc_q, 32'h0);
      chk("R1", "wr_en in reset", {31'h0, wr_en}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "acc after reset", acc_q, 32'h0);
      chk("R1", "flags after reset", {30'h0, carry, ovf}, 32'h0);
      // directed corners
      do_op(1, 4'd7, 1, 16'h7FFF, 16'h0, 0, 5'd16, 0);   // R8 -> 7FFF0000
      do_op(1, 4'd1, 0, 16'h0, 16'hFFFF, 0, 5'd0, 0);    // R3 -> 7FFFFFFF
      do_op(1, 4'd1, 1, 16'h0001, 16'h0, 0, 5'd0, 0);    // R5 positive overflow
      do_op(1, 4'd2, 1, 16'h0001, 16'h0, 0, 5'd0, 0);    // R5 negative overflow on sub
      do_op(1, 4'd7, 1, 16'h0000, 16'h0, 0, 5'd0, 0);
      do_op(1, 4'd2, 1, 16'h0001, 16'h0, 0, 5'd0, 0);    // R5 borrow -> carry 0
      do_op(1, 4'd7, 0, 16'h0, 16'h8001, 1, 5'd20, 0);   // R2 clamp to 16
      do_op(1, 4'd7, 1, 16'h8000, 16'h0, 1, 5'd4, 0);    // R2 sign extend
      do_op(1, 4'd7, 1, 16'h8000, 16'h0, 0, 5'd4, 0);    // R2 zero extend
      do_op(1, 4'd6, 1, 16'h1234, 16'h0, 1, 5'd9, 0);    // R7 high half kept
      do_op(1, 4'd8, 1, 16'h0, 16'h0, 0, 5'd7, 1);       // R9 high half, bits cross
      do_op(1, 4'd8, 1, 16'h0, 16'h0, 0, 5'd3, 0);       // R9 low half
      do_op(1, 4'd15, 1, 16'hFFFF, 16'hFFFF, 1, 5'd0, 0); // R10 unused code
      do_op(0, 4'd1, 1, 16'hFFFF, 16'hFFFF, 1, 5'd0, 0);  // R10 strobe low
      do_op(1, 4'd5, 1, 16'hFFFF, 16'h0, 1, 5'd0, 0);     // R6 xor
      // constrained random
      for (int i = 0; i < 400; i++) begin
         int          r;
         logic [3:0]  op;
         r = int'($urandom % 10);
         op = (r == 9) ? 4'd15 : 4'(r);
         do_op(($urandom % 10) != 0, op, 1'($urandom), 16'($urandom),
               16'($urandom), 1'($urandom), 5'($urandom % 21), 1'($urandom));
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule